// File: doc/BRIEF.md
# Cumulative-Boundary Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a parallel RGB panel, one pixel per clock, together with the current scan line and a one-clock line-match event. The frame geometry comes in four timing words. Each word holds one horizontal value and one vertical value. The values are running totals measured from the first clock of sync, not separate lengths: the sync word holds the sync width minus one; the back-porch word adds the back porch to that; the active word then adds the visible size; and the total word then adds the front porch.

A global control word starts and stops the scan and chooses the polarity of each panel signal. HSYNC, VSYNC and DE are active low unless their polarity bit is set. A further bit asks for the pixel clock to be inverted; the block passes that request to the clock logic outside it. Every configuration value arrives on a plain input port. There is no bus decoding and no data stream, so the block has no valid/ready handshake. The line-target input picks the line on which the line-match event fires. Setting it to the accumulated active height plus one makes the event mark the start of vertical blanking.

Top module: `disp_timing_gen`

## Requirements
- R1: In every timing word, the horizontal value is bits 27:16 and the vertical value is bits 10:0. All other bits are ignored.
- R2: While enabled, the pixel counter steps once per clock from 0 up to the total-width value inclusive, then returns to 0.
- R3: The line counter steps once each time the pixel counter returns to 0. After the total-height value it returns to 0.
- R4: HSYNC is asserted while the pixel counter is at or below the horizontal sync value. VSYNC is asserted while the line counter is at or below the vertical sync value.
- R5: DE is asserted only when the pixel counter is strictly above the horizontal back-porch value and at or below the horizontal active value, and the line counter meets the same test against the vertical values.
- R6: Control bit 31 makes HSYNC active high, bit 30 makes VSYNC active high and bit 29 makes DE active high. When a bit is 0, its signal is active low, so its inactive level is 1.
- R7: The pixel-clock-invert output equals control bit 28 at all times, whether or not the scan is enabled.
- R8: While control bit 0 (enable) is 0, HSYNC, VSYNC and DE sit at their inactive levels and the line-match output stays low. From the next clock edge both counters read 0.
- R9: The line-match output is high for exactly one clock. It fires on pixel 0 of the line whose number equals the line-target input, and it never fires for a target beyond the total height.
- R10: The status output carries the current line number in bits 15:0. The line number is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 32 | Control word: bit 0 enable, bits 31..28 HSYNC/VSYNC/DE/pixel-clock polarity |
| sync_cfg_i | input | 32 | Sync width minus one (horizontal 27:16, vertical 10:0) |
| bporch_cfg_i | input | 32 | Accumulated back-porch boundary |
| active_cfg_i | input | 32 | Accumulated active boundary |
| total_cfg_i | input | 32 | Accumulated total boundary |
| line_tgt_i | input | 11 | Line on which the line-match event fires |
| hsync_o | output | 1 | Horizontal sync at the selected polarity |
| vsync_o | output | 1 | Vertical sync at the selected polarity |
| de_o | output | 1 | Data enable at the selected polarity |
| pclk_inv_o | output | 1 | Request to invert the pixel clock |
| scan_pos_o | output | 16 | Current line number |
| line_hit_o | output | 1 | One-clock line-match event |

## Verification
The checker watches relations that must hold on every cycle:

- While disabled, the outputs sit at their inactive levels, and the line number is 0 one clock later.
- A line-match event only ever appears on the target line, and it never lasts a second clock.
- An asserted DE or VSYNC only ever appears inside its vertical window.

The per-pixel sequence of a frame can only be shown by the bench. Several geometries and polarity sets drive it, and the bench compares every sync, DE and line value with a count-based expectation. The bench alone also shows:

- the number of DE pixels per frame;
- a line target that lies past the frame;
- junk bits outside the timing fields;
- a mid-frame disable.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int WORD_W  = 32;
  localparam int H_W     = 12;
  localparam int V_W     = 11;
  localparam int H_LSB   = 16;
  localparam int V_LSB   = 0;
  localparam int STAT_W  = 16;
  localparam int EN_BIT  = 0;
  localparam int HPOL_BIT = 31;
  localparam int VPOL_BIT = 30;
  localparam int DPOL_BIT = 29;
  localparam int CPOL_BIT = 28;

  function automatic logic [H_W-1:0] h_field(input logic [WORD_W-1:0] w);
    return w[H_LSB +: H_W];
  endfunction

  function automatic logic [V_W-1:0] v_field(input logic [WORD_W-1:0] w);
    return w[V_LSB +: V_W];
  endfunction

  // level driven onto a pin: polarity bit set means active high
  function automatic logic drive_level(input logic active, input logic pol_high);
    return active ? pol_high : ~pol_high;
  endfunction
endpackage

// File: rtl/dtg_scan_counter.sv
module dtg_scan_counter #(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [H_W-1:0] h_last,
  input  logic [V_W-1:0] v_last,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt
);
  logic h_end;
  logic v_end;

  assign h_end = (h_cnt >= h_last);
  assign v_end = (v_cnt >= v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (!run) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_end) begin
      h_cnt <= '0;
      v_cnt <= v_end ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dtg_axis_decode.sv
module dtg_axis_decode #(
  parameter int W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] sync_b,
  input  logic [W-1:0] bp_b,
  input  logic [W-1:0] act_b,
  output logic         in_sync,
  output logic         in_active
);
  always_comb begin
    in_sync   = (cnt <= sync_b);
    in_active = (cnt > bp_b) && (cnt <= act_b);
  end
endmodule

// File: rtl/dtg_line_match.sv
module dtg_line_match #(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           run,
  input  logic [H_W-1:0] h_cnt,
  input  logic [V_W-1:0] v_cnt,
  input  logic [V_W-1:0] target,
  output logic           hit
);
  assign hit = run && (h_cnt == '0) && (v_cnt == target);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int HB        = H_W,
  parameter int VB        = V_W,
  parameter int SB        = STAT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_BITS-1:0] ctrl_i,
  input  logic [WORD_BITS-1:0] sync_cfg_i,
  input  logic [WORD_BITS-1:0] bporch_cfg_i,
  input  logic [WORD_BITS-1:0] active_cfg_i,
  input  logic [WORD_BITS-1:0] total_cfg_i,
  input  logic [VB-1:0]        line_tgt_i,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 de_o,
  output logic                 pclk_inv_o,
  output logic [SB-1:0]        scan_pos_o,
  output logic                 line_hit_o
);
  localparam int PAD_W = SB - VB;

  logic          run;
  logic [HB-1:0] h_cnt;
  logic [VB-1:0] v_cnt;
  logic          h_sync_q, h_act;
  logic          v_sync_q, v_act;

  assign run = ctrl_i[EN_BIT];

  dtg_scan_counter #(.H_W(HB), .V_W(VB)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .h_last (h_field(total_cfg_i)),
    .v_last (v_field(total_cfg_i)),
    .h_cnt  (h_cnt),
    .v_cnt  (v_cnt)
  );

  dtg_axis_decode #(.W(HB)) u_hdec (
    .cnt       (h_cnt),
    .sync_b    (h_field(sync_cfg_i)),
    .bp_b      (h_field(bporch_cfg_i)),
    .act_b     (h_field(active_cfg_i)),
    .in_sync   (h_sync_q),
    .in_active (h_act)
  );

  dtg_axis_decode #(.W(VB)) u_vdec (
    .cnt       (v_cnt),
    .sync_b    (v_field(sync_cfg_i)),
    .bp_b      (v_field(bporch_cfg_i)),
    .act_b     (v_field(active_cfg_i)),
    .in_sync   (v_sync_q),
    .in_active (v_act)
  );

  dtg_line_match #(.H_W(HB), .V_W(VB)) u_match (
    .run    (run),
    .h_cnt  (h_cnt),
    .v_cnt  (v_cnt),
    .target (line_tgt_i),
    .hit    (line_hit_o)
  );

  always_comb begin
    hsync_o    = drive_level(run && h_sync_q, ctrl_i[HPOL_BIT]);
    vsync_o    = drive_level(run && v_sync_q, ctrl_i[VPOL_BIT]);
    de_o       = drive_level(run && h_act && v_act, ctrl_i[DPOL_BIT]);
    pclk_inv_o = ctrl_i[CPOL_BIT];
    scan_pos_o = {{PAD_W{1'b0}}, v_cnt};
  end
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_i,
  input logic [31:0] sync_cfg_i,
  input logic [31:0] bporch_cfg_i,
  input logic [31:0] active_cfg_i,
  input logic [31:0] total_cfg_i,
  input logic [10:0] line_tgt_i,
  input logic        hsync_o,
  input logic        vsync_o,
  input logic        de_o,
  input logic [15:0] scan_pos_o,
  input logic        line_hit_o
);
  a_r8_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[0] |-> (hsync_o == !ctrl_i[31]) && (vsync_o == !ctrl_i[30]) &&
                   (de_o == !ctrl_i[29]) && !line_hit_o);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[0] |=> (scan_pos_o == 16'd0));

  a_r9_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit_o |-> (scan_pos_o == {5'd0, line_tgt_i}));

  a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hit_o && total_cfg_i[27:16] != 12'd0) |=>
      (!line_hit_o || !$stable(total_cfg_i) || !$stable(line_tgt_i)));

  a_r5_de_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[0] && de_o == ctrl_i[29]) |->
      (scan_pos_o > {5'd0, bporch_cfg_i[10:0]}) && (scan_pos_o <= {5'd0, active_cfg_i[10:0]}));

  a_r4_vsync_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[0] && vsync_o == ctrl_i[30]) |-> (scan_pos_o <= {5'd0, sync_cfg_i[10:0]}));
endmodule

bind disp_timing_gen dtg_checker i_dtg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_i       (ctrl_i),
  .sync_cfg_i   (sync_cfg_i),
  .bporch_cfg_i (bporch_cfg_i),
  .active_cfg_i (active_cfg_i),
  .total_cfg_i  (total_cfg_i),
  .line_tgt_i   (line_tgt_i),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .de_o         (de_o),
  .scan_pos_o   (scan_pos_o),
  .line_hit_o   (line_hit_o)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 3;

  function automatic logic [31:0] mk(input int h, input int v);
    return (32'(h) << 16) | 32'(v);
  endfunction

  localparam logic [31:0] T_CTRL [NV] = '{32'h0000_0001, 32'hF000_0001, 32'hA000_0001};
  localparam logic [31:0] T_SYNC [NV] = '{32'h0001_0000, 32'h0000_0001, 32'h0002_0000};
  localparam logic [31:0] T_BP   [NV] = '{32'h0003_0001, 32'h0002_0002, 32'h0004_0000};
  localparam logic [31:0] T_ACT  [NV] = '{32'h0007_0004, 32'h0008_0005, 32'h0006_0002};
  localparam logic [31:0] T_TOT  [NV] = '{32'h0009_0005, 32'h000B_0007, 32'h0007_0003};
  localparam logic [10:0] T_TGT  [NV] = '{11'd5, 11'd3, 11'd9};
  localparam int          T_DE   [NV] = '{12, 18, 4};
  localparam int          T_HIT  [NV] = '{1, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [31:0] sync_cfg_i = '0, bporch_cfg_i = '0, active_cfg_i = '0, total_cfg_i = '0;
  logic [10:0] line_tgt_i = '0;
  logic        hsync_o, vsync_o, de_o, pclk_inv_o, line_hit_o;
  logic [15:0] scan_pos_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_timing_gen i_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .sync_cfg_i(sync_cfg_i),
    .bporch_cfg_i(bporch_cfg_i), .active_cfg_i(active_cfg_i), .total_cfg_i(total_cfg_i),
    .line_tgt_i(line_tgt_i), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pclk_inv_o(pclk_inv_o), .scan_pos_o(scan_pos_o), .line_hit_o(line_hit_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frames(input logic [31:0] c, input logic [31:0] s, input logic [31:0] b,
                            input logic [31:0] a, input logic [31:0] t, input logic [10:0] tg,
                            input int frames, input int exp_de, input int exp_hit);
    int sh, sv, bh, bv, ah, av, th, tv, de_n, hit_n;
    sh = int'(s[27:16]); sv = int'(s[10:0]);
    bh = int'(b[27:16]); bv = int'(b[10:0]);
    ah = int'(a[27:16]); av = int'(a[10:0]);
    th = int'(t[27:16]); tv = int'(t[10:0]);
    de_n = 0; hit_n = 0;
    @(negedge clk);
    ctrl_i = c & ~32'h1; sync_cfg_i = s; bporch_cfg_i = b; active_cfg_i = a;
    total_cfg_i = t; line_tgt_i = tg;
    @(negedge clk);
    ctrl_i = c;
    for (int k = 0; k < frames * (th + 1) * (tv + 1); k++) begin
      int h, v;
      bit hs, vs, de, hit;
      #(CLK_PERIOD/4);
      h = k % (th + 1);
      v = (k / (th + 1)) % (tv + 1);
      hs  = (h <= sh);
      vs  = (v <= sv);
      de  = (h > bh) && (h <= ah) && (v > bv) && (v <= av);
      hit = (h == 0) && (v == int'(tg));
      chk(hsync_o == (hs ? c[31] : ~c[31]), "R4/R6/R1 hsync", int'(hsync_o), int'(hs ? c[31] : ~c[31]));
      chk(vsync_o == (vs ? c[30] : ~c[30]), "R4/R6/R1 vsync", int'(vsync_o), int'(vs ? c[30] : ~c[30]));
      chk(de_o == (de ? c[29] : ~c[29]), "R5/R6 de", int'(de_o), int'(de ? c[29] : ~c[29]));
      chk(line_hit_o == hit, "R9 line_hit", int'(line_hit_o), int'(hit));
      chk(scan_pos_o == 16'(v), "R2/R3/R10 scan_pos", int'(scan_pos_o), v);
      chk(pclk_inv_o == c[28], "R7 pclk_inv", int'(pclk_inv_o), int'(c[28]));
      if (de_o == c[29]) de_n++;
      if (line_hit_o) hit_n++;
      @(negedge clk);
    end
    chk(de_n == exp_de * frames, "R5 DE pixel count", de_n, exp_de * frames);
    chk(hit_n == exp_hit * frames, "R9 line match count", hit_n, exp_hit * frames);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state, R8: disabled, active-low polarity -> inactive level 1
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(hsync_o == 1'b1, "R8 reset hsync", int'(hsync_o), 1);
    chk(vsync_o == 1'b1, "R8 reset vsync", int'(vsync_o), 1);
    chk(de_o == 1'b1, "R8 reset de", int'(de_o), 1);
    chk(line_hit_o == 1'b0, "R8 reset line_hit", int'(line_hit_o), 0);
    chk(scan_pos_o == 16'd0, "R10 reset scan_pos", int'(scan_pos_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_frames(T_CTRL[i], T_SYNC[i], T_BP[i], T_ACT[i], T_TOT[i], T_TGT[i], 2, T_DE[i], T_HIT[i]);

    // R1: bits outside both fields must be ignored
    run_frames(32'h0000_0001, 32'hF001_F800 | mk(0, 0) | 32'h0001_0000, 32'hF000_F800 | mk(3, 1),
               32'hF000_F800 | mk(7, 4), 32'hF000_F800 | mk(9, 5), 11'd5, 1, 12, 1);

    // R8: mid-frame disable, enabled by the frame above; move to line 1, pixel 3
    repeat (13) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(scan_pos_o == 16'd1, "R3 mid-frame line", int'(scan_pos_o), 1);
    @(negedge clk);
    ctrl_i = 32'h0000_0000;
    line_tgt_i = 11'd0;
    #(CLK_PERIOD/4);
    chk(hsync_o == 1'b1 && vsync_o == 1'b1 && de_o == 1'b1, "R8 disable inactive levels",
        int'({hsync_o, vsync_o, de_o}), 7);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      chk(scan_pos_o == 16'd0, "R8 disabled counters zero", int'(scan_pos_o), 0);
      chk(line_hit_o == 1'b0, "R8 no line match while disabled", int'(line_hit_o), 0);
    end

    // R7: clock-invert request follows bit 28 while disabled; R6 inactive level flips with polarity
    @(negedge clk);
    ctrl_i = 32'hF000_0000;
    #(CLK_PERIOD/4);
    chk(pclk_inv_o == 1'b1, "R7 pclk_inv while disabled", int'(pclk_inv_o), 1);
    chk(hsync_o == 1'b0 && vsync_o == 1'b0 && de_o == 1'b0, "R6 active-high inactive levels",
        int'({hsync_o, vsync_o, de_o}), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule